// File: doc/BRIEF.md
# I2C Target Register Access Front-End

This block is the serial front end of a small configuration register bank. It watches an I2C bus, with SCL and SDA already synchronised to the system clock and filtered. When the address matches, it acknowledges and turns each transfer into accesses on a plain register port. SDA is driven open-drain style: the block only ever raises `sda_oe_o`, meaning "pull the line low". It never stretches the clock.

One strap input chooses between two 7-bit target addresses. A write carries a pointer byte and then data bytes. A read may be issued cold, and it then starts at whatever register the pointer holds. Only odd pointer values from 01h to 13h name real registers. Even values and anything above 13h are reserved: they return zero and never produce a write strobe. Register 0Fh is a status register and is read-only. After every data byte the pointer moves to the next odd location and wraps after the last one.

The logic behind the block sees `reg_addr_o`, which always carries the current pointer. It returns that register's contents combinationally on `reg_rdata_i`. It receives a one-cycle `reg_wr_o` strobe with `reg_wdata_o` for every accepted write.

Top module: `i2c_tgt_frontend`

## Requirements
- R1: With `addr_sel_i` = 0 the block acknowledges 7-bit address 1000011 (address byte 86h write, 87h read). With `addr_sel_i` = 1 it acknowledges 1000100 (88h / 89h). Bit 0 of the address byte is 1 for a read.
- R2: When the address byte does not match, SDA stays released (ACK reads as 1, read data reads as FFh) until the next START or STOP, and no write strobe is issued.
- R3: A write is an address byte, then a pointer byte, then data bytes, and each byte is acknowledged. Each data byte aimed at a writable register gives exactly one `reg_wr_o` pulse, with `reg_addr_o` set to the pointer and `reg_wdata_o` set to the byte. SDA only changes while SCL is low.
- R4: After each data byte, read or write, the pointer steps to the next odd value. Odd p below 13h goes to p+2. Even p below 13h goes to p+1. Any p of 13h or above wraps to 01h.
- R5: Data bytes written at a reserved pointer (even, or above 13h) are acknowledged and produce no write strobe.
- R6: Data bytes written at pointer 0Fh are acknowledged and produce no write strobe.
- R7: A read with no pointer byte returns the register at the current pointer. Successive read bytes follow the R4 stepping.
- R8: A read at a reserved pointer returns 00h.
- R9: A repeated START restarts address matching. A pointer written just before it is then used by the read that follows.
- R10: STOP returns the block to idle and releases SDA. The pointer keeps its value across STOP.
- R11: After the controller NACKs a read byte, the block leaves SDA released.
- R12: During reset SDA is released, no write strobe is issued and the pointer is 01h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired bus value) |
| addr_sel_i | input | 1 | Address strap |
| sda_oe_o | output | 1 | Drive SDA low when 1 |
| reg_addr_o | output | 8 | Current register pointer |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Read data for `reg_addr_o` |

## Verification
The bench writes at reserved, even and read-only pointers. A design that gated writes wrongly would strobe there, and the reference model flags any strobe it did not predict. Pointer stepping is checked across the wrap at 13h, from an even pointer and from one above the range. A wrong step rule shows up as data landing at the wrong address or a read returning the wrong byte. It also covers cold reads after STOP, a repeated START between a pointer write and a read, a NACKed final read, and foreign addresses under both strap values. A design that kept driving SDA, or answered the wrong address, would corrupt ACK bits or fail the quiet-bus check.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    LNK_IDLE,
    LNK_ADDR,
    LNK_ACK_ADDR,
    LNK_PTR,
    LNK_ACK_PTR,
    LNK_WDATA,
    LNK_ACK_WDATA,
    LNK_RDATA,
    LNK_RACK,
    LNK_SKIP
  } lnk_state_e;
endpackage

// File: rtl/i2c_tgt_bus_cond.sv
module i2c_tgt_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int          DW       = 8,
  parameter logic [7:0]  LAST_REG = 8'h13,
  parameter logic [7:0]  RO_REG   = 8'h0F,
  parameter logic [7:0]  RST_PTR  = 8'h01
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          adv_i,
  input  logic          wr_pend_i,
  input  logic [DW-1:0] rdata_i,
  output logic [DW-1:0] ptr_o,
  output logic          wr_o,
  output logic [DW-1:0] rd_byte_o
);
  localparam logic [DW-1:0] LAST  = DW'(LAST_REG);
  localparam logic [DW-1:0] RO    = DW'(RO_REG);
  localparam logic [DW-1:0] FIRST = DW'(1);

  logic [DW-1:0] ptr_q, ptr_d;
  logic          valid, writable;

  always_comb begin
    ptr_d = ptr_q;
    if (load_i) begin
      ptr_d = load_val_i;
    end else if (adv_i) begin
      if (ptr_q >= LAST)   ptr_d = FIRST;
      else if (ptr_q[0])   ptr_d = ptr_q + DW'(2);
      else                 ptr_d = ptr_q + DW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= DW'(RST_PTR);
    else if (load_i || adv_i) ptr_q <= ptr_d;
  end

  assign valid     = ptr_q[0] && (ptr_q <= LAST);
  assign writable  = valid && (ptr_q != RO);
  assign wr_o      = wr_pend_i & writable;
  assign rd_byte_o = valid ? rdata_i : '0;
  assign ptr_o     = ptr_q;
endmodule

// File: rtl/i2c_tgt_link.sv
module i2c_tgt_link
  import i2c_tgt_pkg::*;
#(
  parameter int         DW       = 8,
  parameter logic [6:0] TGT_ADR0 = 7'h43,
  parameter logic [6:0] TGT_ADR1 = 7'h44
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_i,
  input  logic          addr_sel_i,
  input  logic          scl_rise_i,
  input  logic          scl_fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [DW-1:0] rd_byte_i,
  output logic          sda_oe_o,
  output logic          ptr_load_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          wr_pend_o,
  output logic          rd_adv_o
);
  localparam int          CW       = $clog2(DW + 1);
  localparam logic [CW-1:0] FULL   = CW'(DW);
  localparam int          IW       = $clog2(DW);

  lnk_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rx_q, rx_d;
  logic [DW-1:0] tx_q, tx_d;
  logic          oe_q, oe_d;
  logic          rw_q, rw_d;
  logic          nack_q, nack_d;
  logic          wp_q, wp_d;
  logic [6:0]    my_adr;
  logic [IW-1:0] tx_idx;

  assign my_adr = addr_sel_i ? TGT_ADR1 : TGT_ADR0;
  assign tx_idx = IW'(DW - 1) - cnt_q[IW-1:0];

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    rx_d       = rx_q;
    tx_d       = tx_q;
    oe_d       = oe_q;
    rw_d       = rw_q;
    nack_d     = nack_q;
    wp_d       = 1'b0;
    ptr_load_o = 1'b0;
    rd_adv_o   = 1'b0;
    if (start_i) begin
      st_d  = LNK_ADDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else if (stop_i) begin
      st_d  = LNK_IDLE;
      oe_d  = 1'b0;
    end else begin
      unique case (st_q)
        LNK_ADDR, LNK_PTR, LNK_WDATA: begin
          if (scl_rise_i && cnt_q != FULL) begin
            rx_d  = {rx_q[DW-2:0], sda_i};
            cnt_d = cnt_q + CW'(1);
          end else if (scl_fall_i && cnt_q == FULL) begin
            cnt_d = '0;
            if (st_q == LNK_ADDR) begin
              if (rx_q[DW-1:1] == my_adr) begin
                oe_d = 1'b1;
                rw_d = rx_q[0];
                st_d = LNK_ACK_ADDR;
              end else begin
                st_d = LNK_SKIP;
              end
            end else if (st_q == LNK_PTR) begin
              ptr_load_o = 1'b1;
              oe_d       = 1'b1;
              st_d       = LNK_ACK_PTR;
            end else begin
              wp_d = 1'b1;
              oe_d = 1'b1;
              st_d = LNK_ACK_WDATA;
            end
          end
        end
        LNK_ACK_ADDR: begin
          if (scl_fall_i) begin
            if (rw_q) begin
              tx_d  = rd_byte_i;
              oe_d  = ~rd_byte_i[DW-1];
              cnt_d = '0;
              st_d  = LNK_RDATA;
            end else begin
              oe_d = 1'b0;
              st_d = LNK_PTR;
            end
          end
        end
        LNK_ACK_PTR, LNK_ACK_WDATA: begin
          if (scl_fall_i) begin
            oe_d = 1'b0;
            st_d = LNK_WDATA;
          end
        end
        LNK_RDATA: begin
          if (scl_rise_i && cnt_q != FULL) begin
            cnt_d = cnt_q + CW'(1);
          end else if (scl_fall_i && cnt_q == FULL) begin
            oe_d     = 1'b0;
            rd_adv_o = 1'b1;
            cnt_d    = '0;
            st_d     = LNK_RACK;
          end else if (scl_fall_i && cnt_q != '0) begin
            oe_d = ~tx_q[tx_idx];
          end
        end
        LNK_RACK: begin
          if (scl_rise_i) begin
            nack_d = sda_i;
          end else if (scl_fall_i) begin
            if (!nack_q) begin
              tx_d = rd_byte_i;
              oe_d = ~rd_byte_i[DW-1];
              st_d = LNK_RDATA;
            end else begin
              oe_d = 1'b0;
              st_d = LNK_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LNK_IDLE;
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      nack_q <= 1'b1;
      wp_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      oe_q   <= oe_d;
      rw_q   <= rw_d;
      nack_q <= nack_d;
      wp_q   <= wp_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign rx_byte_o = rx_q;
  assign wr_pend_o = wp_q;
endmodule

// File: rtl/i2c_tgt_frontend.sv
module i2c_tgt_frontend #(
  parameter int         DW       = 8,
  parameter logic [6:0] TGT_ADR0 = 7'h43,
  parameter logic [6:0] TGT_ADR1 = 7'h44,
  parameter logic [7:0] LAST_REG = 8'h13,
  parameter logic [7:0] RO_REG   = 8'h0F
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          addr_sel_i,
  output logic          sda_oe_o,
  output logic [DW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o,
  input  logic [DW-1:0] reg_rdata_i
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          rise, fall, st_ev, sp_ev;
  logic          ptr_load, wr_pend, rd_adv;
  logic [DW-1:0] rx_byte, rd_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  i2c_tgt_bus_cond u_cond (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (rise),
    .scl_fall_o (fall),
    .start_o    (st_ev),
    .stop_o     (sp_ev)
  );

  i2c_tgt_link #(
    .DW       (DW),
    .TGT_ADR0 (TGT_ADR0),
    .TGT_ADR1 (TGT_ADR1)
  ) u_link (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sda_i      (sda_i),
    .addr_sel_i (addr_sel_i),
    .scl_rise_i (rise),
    .scl_fall_i (fall),
    .start_i    (st_ev),
    .stop_i     (sp_ev),
    .rd_byte_i  (rd_byte),
    .sda_oe_o   (sda_oe_o),
    .ptr_load_o (ptr_load),
    .rx_byte_o  (rx_byte),
    .wr_pend_o  (wr_pend),
    .rd_adv_o   (rd_adv)
  );

  i2c_tgt_ptr #(
    .DW       (DW),
    .LAST_REG (LAST_REG),
    .RO_REG   (RO_REG),
    .RST_PTR  (8'h01)
  ) u_ptr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (ptr_load),
    .load_val_i (rx_byte),
    .adv_i      (wr_pend | rd_adv),
    .wr_pend_i  (wr_pend),
    .rdata_i    (reg_rdata_i),
    .ptr_o      (reg_addr_o),
    .wr_o       (reg_wr_o),
    .rd_byte_o  (rd_byte)
  );

  assign reg_wdata_o = rx_byte;
endmodule

// File: rtl/i2c_tgt_sva.sv
module i2c_tgt_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       sda_i,
  input logic       sda_oe_o,
  input logic [7:0] reg_addr_o,
  input logic       reg_wr_o
);
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (reg_addr_o[0] && reg_addr_o <= 8'h13)); // R5

  AST_WR_NOT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |-> (reg_addr_o != 8'h0F)); // R6

  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> !reg_wr_o); // R3

  AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe_o)); // R3

  AST_PTR_STEP_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> (reg_addr_o == (($past(reg_addr_o) == 8'h13) ? 8'h01
                                 : $past(reg_addr_o) + 8'd2))); // R4

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o); // R10
endmodule

bind i2c_tgt_frontend i2c_tgt_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_i      (scl_i),
  .sda_i      (sda_i),
  .sda_oe_o   (sda_oe_o),
  .reg_addr_o (reg_addr_o),
  .reg_wr_o   (reg_wr_o)
);

// File: tb/i2c_tgt_frontend_tb_top.sv
module i2c_tgt_frontend_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       m_scl, m_sda, addr_sel;
  logic       sda_bus;
  logic       sda_oe;
  logic [7:0] reg_addr, reg_wdata, reg_rdata;
  logic       reg_wr;

  logic [7:0]  mem [0:255];
  logic [15:0] exp_wr [$];
  int          n_chk = 0;
  int          n_err = 0;
  int          mptr = 1;
  bit          quiet = 1'b0;
  bit          done = 1'b0;
  bit          live = 1'b0;

  always #4 clk = ~clk;

  assign sda_bus   = m_sda & ~sda_oe;
  assign reg_rdata = mem[reg_addr];

  i2c_tgt_frontend dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .addr_sel_i  (addr_sel),
    .sda_oe_o    (sda_oe),
    .reg_addr_o  (reg_addr),
    .reg_wr_o    (reg_wr),
    .reg_wdata_o (reg_wdata),
    .reg_rdata_i (reg_rdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit vld(input int p);
    return (p % 2 == 1) && (p <= 19);
  endfunction

  function automatic int nxt(input int p);
    if (p >= 19) return 1;
    return (p % 2 == 1) ? p + 2 : p + 1;
  endfunction

  // reference model of the register side: predicted strobes compared every clock
  always @(negedge clk) begin
    if (live && reg_wr) begin
      if (exp_wr.size() == 0) begin
        chk(1'b0, "R5 unexpected write", {reg_addr, reg_wdata}, 0);
      end else begin
        logic [15:0] e;
        e = exp_wr.pop_front();
        chk({reg_addr, reg_wdata} == e, "R3 write addr/data", {reg_addr, reg_wdata}, e);
      end
      if (reg_addr != 8'h0F) mem[reg_addr] = reg_wdata;
    end
    if (live && quiet) chk(!sda_oe, "R2 sda released", sda_oe, 0);
  end

  task automatic wq();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq(); wq();
  endtask

  task automatic send(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
    end
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); ack = sda_bus; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic recv(output logic [7:0] b, input logic nack);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); m_scl = 1'b1; wq(); b = {b[6:0], sda_bus}; wq(); m_scl = 1'b0;
    end
    wq(); m_sda = nack; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; m_sda = 1'b1; wq();
  endtask

  task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input string tag);
    logic ack;
    logic [7:0] d;
    bus_start();
    send({a, 1'b0}, ack); chk(ack == 1'b0, "R1 address ack", ack, 0);
    send(p, ack);         chk(ack == 1'b0, "R3 pointer ack", ack, 0);
    mptr = p;
    for (int k = 0; k < n; k++) begin
      d = (k == 0) ? d0 : d1;
      if (vld(mptr) && mptr != 15) exp_wr.push_back({mptr[7:0], d});
      send(d, ack); chk(ack == 1'b0, tag, ack, 0);
      mptr = nxt(mptr);
    end
    bus_stop();
    repeat (4) @(negedge clk);
    chk(exp_wr.size() == 0, tag, exp_wr.size(), 0);
    chk(reg_addr == mptr[7:0], "R4 pointer after write", reg_addr, mptr);
  endtask

  task automatic rd_bytes(input int n, input string tag);
    logic [7:0] b, e;
    for (int k = 0; k < n; k++) begin
      e = vld(mptr) ? mem[mptr] : 8'h00;
      recv(b, k == n - 1);
      chk(b == e, tag, b, e);
      mptr = nxt(mptr);
    end
    repeat (2) @(negedge clk);
    chk(!sda_oe, "R11 released after nack", sda_oe, 0);
  endtask

  task automatic rd_txn(input logic [6:0] a, input int n, input string tag);
    logic ack;
    bus_start();
    send({a, 1'b1}, ack); chk(ack == 1'b0, "R1 read address ack", ack, 0);
    rd_bytes(n, tag);
    bus_stop();
    chk(reg_addr == mptr[7:0], "R10 pointer kept", reg_addr, mptr);
  endtask

  task automatic foreign(input logic [6:0] a);
    logic ack;
    logic [7:0] b;
    bus_start();
    quiet = 1'b1;
    send({a, 1'b0}, ack); chk(ack == 1'b1, "R2 write address nack", ack, 1);
    send(8'h03, ack);     chk(ack == 1'b1, "R2 byte nack", ack, 1);
    send(8'hE7, ack);     chk(ack == 1'b1, "R2 byte nack", ack, 1);
    bus_start();
    send({a, 1'b1}, ack); chk(ack == 1'b1, "R2 read address nack", ack, 1);
    recv(b, 1'b1);        chk(b == 8'hFF, "R2 read released", b, 8'hFF);
    bus_stop();
    quiet = 1'b0;
    chk(reg_addr == mptr[7:0], "R2 pointer untouched", reg_addr, mptr);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
    mem[8'h0F] = 8'h5A;
    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; addr_sel = 1'b0;
    repeat (5) @(negedge clk);
    chk(!sda_oe, "R12 sda released in reset", sda_oe, 0);
    chk(!reg_wr, "R12 no write in reset", reg_wr, 0);
    chk(reg_addr == 8'h01, "R12 pointer reset", reg_addr, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    live = 1'b1;

    wr_txn(7'h43, 8'h03, 2, 8'h11, 8'h22, "R3 data ack");
    rd_txn(7'h43, 2, "R7 cold read");
    wr_txn(7'h43, 8'h13, 2, 8'h33, 8'h44, "R4 wrap write");
    wr_txn(7'h43, 8'h04, 2, 8'h55, 8'h66, "R5 reserved even");
    wr_txn(7'h43, 8'h0F, 2, 8'h77, 8'h88, "R6 status write");
    wr_txn(7'h43, 8'h20, 2, 8'h99, 8'hAA, "R5 above range");

    begin : rep_start_r9
      logic ack;
      bus_start();
      send(8'h86, ack); chk(ack == 1'b0, "R9 address ack", ack, 0);
      send(8'h0A, ack); chk(ack == 1'b0, "R9 pointer ack", ack, 0);
      mptr = 8'h0A;
      bus_start();
      send(8'h87, ack); chk(ack == 1'b0, "R9 read address ack", ack, 0);
      rd_bytes(2, "R8 reserved read then next");
      bus_stop();
    end

    rd_txn(7'h43, 1, "R10 read after stop");
    wr_txn(7'h43, 8'h0F, 0, 8'h00, 8'h00, "R7 pointer only");
    rd_txn(7'h43, 3, "R7 read status and on");
    foreign(7'h44);

    addr_sel = 1'b1;
    repeat (4) @(negedge clk);
    wr_txn(7'h44, 8'h09, 1, 8'hC3, 8'h00, "R1 strap one write");
    rd_txn(7'h44, 1, "R1 strap one read");
    foreign(7'h43);

    chk(exp_wr.size() == 0, "R3 all writes seen", exp_wr.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end
endmodule